// File: doc/BRIEF.md
# Power-Down Mode Control Register

This block holds an 8-bit standby control register and runs the small mode controller behind it. Software writes the register through a plain write port and reads it back combinationally. When the CPU signals a sleep instruction with a one-cycle strobe, the controller leaves its running state. The mode-select bit chooses whether it enters light sleep or deep standby. Standby is refused while the watchdog is enabled. A refused standby request becomes an ordinary sleep and sets a sticky error flag.

While in standby, a second register bit decides whether the chip's output pins keep their driven value or float. Four further bits stop the clocks of individual peripheral modules. A stopped module keeps its register contents, because its clock simply halts. Each clock enable is the inverse of its stop bit, and all enables are forced low in standby. Any wake input returns the controller to the running state on the next clock edge.

The register port is control, not a data stream. It has no valid/ready handshake, and a write strobe is accepted in every cycle with no back-pressure. The sleep, wake and watchdog inputs are plain level or strobe signals.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the state is RUN, pin_hiz is 0, every module clock enable is 1 and the error flag is 0.
- R2: Register bits 2 and 0 always read 0, and writes to them are ignored. Bits 7, 6, 5, 4, 3 and 1 are read/write.
- R3: A write takes effect on the clock edge where reg_wr_en is high. From the next cycle the read value equals the written data with bits 2 and 0 cleared. Without a write the register holds its value.
- R4: In RUN, a sleep request with bit 7 = 0 moves the controller to SLEEP on the next edge.
- R5: In RUN, a sleep request with bit 7 = 1 and wdt_en = 0 moves the controller to STANDBY on the next edge. STANDBY is never entered when wdt_en was 1 at the entry edge.
- R6: In RUN, a sleep request with bit 7 = 1 and wdt_en = 1 moves the controller to SLEEP and sets the error flag. The flag then stays set until reset.
- R7: In SLEEP or STANDBY, wake returns the controller to RUN on the next edge, and sleep requests there are ignored. In RUN, wake has no effect, and a sleep request in the same cycle as wake is still taken.
- R8: pin_hiz is 1 exactly when the state is STANDBY and bit 6 is 1. It falls in the same cycle that the state leaves STANDBY.
- R9: Outside STANDBY, the module clock enables are mod_clk_en[0] = ~bit1, [1] = ~bit3, [2] = ~bit4 and [3] = ~bit5. In STANDBY all four are 0.
- R10: mode_state encodes RUN as 0, SLEEP as 1 and STANDBY as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read value |
| sleep_req | input | 1 | Sleep instruction strobe from the CPU |
| wdt_en | input | 1 | Watchdog timer enable status |
| wake | input | 1 | Wake / interrupt request |
| pin_hiz | output | 1 | Float output pins |
| mod_clk_en | output | 4 | Per-module clock enables |
| mode_state | output | 2 | Controller state |
| wdt_err | output | 1 | Sticky flag for a refused standby |

## Verification
The hardest situation to reach is the refused standby, where bit 7 is set and a sleep request arrives while the watchdog is enabled. It must produce a plain sleep with a sticky error flag rather than a standby. The stimulus writes the mode bit, holds wdt_en high across the sleep strobe, and checks that the flag survives a wake and later legal standby entries. A seeded random phase mixes writes, sleep strobes, wakes and watchdog toggles, including sleep and wake in the same cycle. A behavioural reference model is compared on every clock throughout.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int REG_W    = 8;
  localparam int N_MOD    = 4;
  localparam int MODE_BIT = 7;
  localparam int HIZ_BIT  = 6;
  localparam logic [REG_W-1:0] WR_MASK = 8'hFA;

  typedef enum logic [1:0] {
    PD_RUN     = 2'd0,
    PD_SLEEP   = 2'd1,
    PD_STANDBY = 2'd2
  } pd_state_e;

  function automatic int stop_pos(input int idx);
    return (idx == 0) ? 1 : idx + 2;
  endfunction
endpackage

// File: rtl/pdc_reg.sv
module pdc_reg
  import pdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             mode_sel,
  output logic             hiz_sel,
  output logic [N_MOD-1:0] stop
);
  logic [REG_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data & WR_MASK;
  end

  assign rd_data  = q;
  assign mode_sel = q[MODE_BIT];
  assign hiz_sel  = q[HIZ_BIT];

  for (genvar g = 0; g < N_MOD; g++) begin : g_stop
    assign stop[g] = q[stop_pos(g)];
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] == 1'b0) && (rd_data[0] == 1'b0));
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & 8'hFA));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wdt_en,
  input  logic      wake,
  input  logic      mode_sel,
  output pd_state_e state,
  output logic      err
);
  pd_state_e st_nxt;
  logic      refuse;

  assign refuse = sleep_req && mode_sel && wdt_en;

  always_comb begin
    st_nxt = state;
    case (state)
      PD_RUN: begin
        if (sleep_req) st_nxt = (mode_sel && !wdt_en) ? PD_STANDBY : PD_SLEEP;
      end
      PD_SLEEP, PD_STANDBY: begin
        if (wake) st_nxt = PD_RUN;
      end
      default: st_nxt = PD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PD_RUN;
      err   <= 1'b0;
    end else begin
      state <= st_nxt;
      if (state == PD_RUN && refuse) err <= 1'b1;
    end
  end

  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_RUN && sleep_req && !mode_sel) |=> state == PD_SLEEP);
  a_r5_standby_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_STANDBY && $past(state) != PD_STANDBY) |-> !$past(wdt_en));
  a_r6_refused_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PD_RUN && sleep_req && mode_sel && wdt_en) |=> (state == PD_SLEEP && err));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r7_wake_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PD_RUN && wake) |=> state == PD_RUN);
endmodule

// File: rtl/pdc_clkgate.sv
module pdc_clkgate
  import pdc_pkg::*;
(
  input  logic [N_MOD-1:0] stop,
  input  logic             in_standby,
  output logic [N_MOD-1:0] clk_en
);
  for (genvar g = 0; g < N_MOD; g++) begin : g_en
    assign clk_en[g] = !stop[g] && !in_standby;
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  output logic [7:0] reg_rd_data,
  input  logic       sleep_req,
  input  logic       wdt_en,
  input  logic       wake,
  output logic       pin_hiz,
  output logic [3:0] mod_clk_en,
  output logic [1:0] mode_state,
  output logic       wdt_err
);
  logic             mode_sel, hiz_sel;
  logic [N_MOD-1:0] stop;
  pd_state_e        state;

  pdc_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .rd_data(reg_rd_data), .mode_sel(mode_sel), .hiz_sel(hiz_sel), .stop(stop)
  );

  pdc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wdt_en(wdt_en),
    .wake(wake), .mode_sel(mode_sel), .state(state), .err(wdt_err)
  );

  pdc_clkgate u_gate (
    .stop(stop), .in_standby(state == PD_STANDBY), .clk_en(mod_clk_en)
  );

  assign pin_hiz    = (state == PD_STANDBY) && hiz_sel;
  assign mode_state = state;

  a_r8_hiz_only_standby: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hiz |-> mode_state == 2'd2);
  a_r9_standby_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 2'd2) |-> mod_clk_en == 4'b0000);
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode_state != 2'd3);
endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic       sleep_req = 1'b0, wdt_en = 1'b0, wake = 1'b0;
  logic [7:0] reg_rd_data;
  logic       pin_hiz, wdt_err;
  logic [3:0] mod_clk_en;
  logic [1:0] mode_state;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // reference model
  int m_reg = 0, m_state = 0, m_err = 0;

  always #5 clk = ~clk;

  pwrdn_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .sleep_req(sleep_req), .wdt_en(wdt_en), .wake(wake),
    .pin_hiz(pin_hiz), .mod_clk_en(mod_clk_en), .mode_state(mode_state), .wdt_err(wdt_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_state = 0; m_err = 0;
    end else begin
      if (m_state == 0) begin
        if (sleep_req) begin
          if ((m_reg & 8'h80) != 0 && !wdt_en) m_state = 2;
          else m_state = 1;
          if ((m_reg & 8'h80) != 0 && wdt_en) m_err = 1;
        end
      end else if (wake) m_state = 0;
      if (reg_wr_en) m_reg = reg_wr_data & 8'hFA;
    end
  end

  function automatic int exp_en();
    int e;
    if (m_state == 2) return 0;
    e = 0;
    if ((m_reg & 8'h02) == 0) e = e | 1;
    if ((m_reg & 8'h08) == 0) e = e | 2;
    if ((m_reg & 8'h10) == 0) e = e | 4;
    if ((m_reg & 8'h20) == 0) e = e | 8;
    return e;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      check("R2/R3 read value", int'(reg_rd_data), m_reg);
      check("R4-R7/R10 state", int'(mode_state), m_state);
      check("R6 error flag", int'(wdt_err), m_err);
      check("R8 pin_hiz", int'(pin_hiz), (m_state == 2 && (m_reg & 8'h40) != 0) ? 1 : 0);
      check("R9 clock enables", int'(mod_clk_en), exp_en());
    end
  end

  task automatic step(input logic we, input logic [7:0] d, input logic sl,
                      input logic wd, input logic wk);
    @(posedge clk); #2;
    reg_wr_en = we; reg_wr_data = d; sleep_req = sl; wdt_en = wd; wake = wk;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = 7;
    #23;
    // R1 reset values
    check("R1 reset reg", int'(reg_rd_data), 0);
    check("R1 reset state", int'(mode_state), 0);
    check("R1 reset hiz", int'(pin_hiz), 0);
    check("R1 reset enables", int'(mod_clk_en), 15);
    check("R1 reset err", int'(wdt_err), 0);
    rst_n = 1'b1;
    step(1, 8'hFF, 0, 0, 0);   // R2: reserved bits cleared, R9 all stopped
    step(0, 8'h00, 0, 0, 0);
    step(1, 8'h00, 0, 0, 0);
    step(1, 8'h0A, 0, 0, 0);   // R9 partial stop
    step(0, 8'h00, 1, 0, 0);   // R4 sleep
    step(0, 8'h00, 1, 0, 0);   // R7 sleep ignored while sleeping
    step(0, 8'h00, 0, 0, 1);   // R7 wake
    step(1, 8'hE8, 0, 0, 0);   // standby + hiz + stops
    step(0, 8'h00, 1, 0, 0);   // R5 standby, R8 hiz
    step(0, 8'h00, 0, 0, 0);
    step(0, 8'h00, 0, 0, 1);   // R8 release on exit
    step(0, 8'h00, 0, 0, 0);
    step(1, 8'h80, 0, 0, 0);   // standby without hiz
    step(0, 8'h00, 1, 0, 0);
    step(0, 8'h00, 0, 0, 1);
    step(0, 8'h00, 1, 1, 0);   // R6 refused standby
    step(0, 8'h00, 0, 1, 1);
    step(0, 8'h00, 1, 0, 1);   // R7 sleep with wake in RUN taken
    step(0, 8'h00, 0, 0, 1);
    step(0, 8'h00, 0, 0, 1);   // R7 wake in RUN no effect
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $random(seed);
      step(r[0] & r[1], r[15:8], r[2] & r[3], r[4] & r[5], r[6] & r[7] & r[16]);
    end
    step(0, 8'h00, 0, 0, 0);
    @(posedge clk); @(negedge clk); #1;
    finish_run();
  end
endmodule